// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves transmit data out of system memory under the control of a circular list of buffer descriptors. Software writes the address of the first descriptor, fills descriptors and buffers, marks each descriptor as handed over to hardware, and then strobes a kick input. The engine reads each descriptor header and buffer pointer over a 32-bit request/acknowledge memory port. It streams the buffer's bytes out on a valid/ready byte interface, then writes the header back with the hand-over bit cleared so that software can reuse the slot. After that it moves to the next slot, or back to the ring start when the slot asks for a wrap.

Buffers are joined into frames. A frame closes at the buffer flagged as the final one. A frame longer than the gather limit (2032 bytes by default) is cut at the limit, and a babble event is pulsed. Single-cycle events also report each released buffer and each completed frame. A kick is honoured only while the controller enable input is high. A kick that comes while a pass is in progress is remembered, and the ring is scanned again as soon as that pass stops.

Top module: `txbd_ring_engine`

## Requirements
- R1: A descriptor at byte address D takes two memory words. The word at D holds the flags in bits [31:16] and the byte count in bits [15:0]. The word at D+4 holds the buffer byte address. Memory is big-endian: the byte at address A sits in bits [31-8*(A mod 4) -: 8] of the word at A with its low two bits cleared.
- R2: A fetched header whose flag bit 15 (owned-by-hardware) is clear stops the pass. The engine makes no write, emits no byte, and keeps its current descriptor address, so the next kick reads that same descriptor again.
- R3: After a descriptor whose flag bit 13 (wrap) is set, the next header read is at the ring start address. Otherwise it is at the current descriptor address plus 8.
- R4: Flag bit 11 (end of frame) makes the final byte of that buffer carry tx_last, and its write-back is followed by an evt_frame_done pulse together with evt_buf_done. No other byte carries tx_last.
- R5: The bytes gathered into one frame never exceed MAX_FRAME (2032). A buffer that would pass the limit gives only the bytes that still fit, and its completion pulses evt_babble.
- R6: After a buffer has been consumed, the engine writes header word D with bit 15 cleared and every other flag bit and the byte count unchanged, then pulses evt_buf_done for one cycle.
- R7: A write to the ring start register clears its low two bits and makes the result both the ring start and the current descriptor address.
- R8: A kick while cfg_en is low is ignored: no memory request is made.
- R9: A kick taken while busy is held, and when the running pass stops at a descriptor not owned by hardware, the engine re-reads that descriptor once without a new kick.
- R10: The frame byte count returns to zero after each frame's end-of-frame buffer and on reset, so the next frame may again gather up to MAX_FRAME bytes.
- R11: After reset, mem_req, tx_valid, busy and all event outputs are low.
- R12: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R13: A buffer address need not be word aligned: the first byte sent is the one at the exact buffer address, and later bytes follow in rising address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Controller enable; kicks are ignored while low |
| ring_base_wr | input | 1 | Write strobe for the ring start register |
| ring_base_data | input | AW | Ring start address to load |
| kick | input | 1 | Transmit kick strobe |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available on tx_data |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Byte is the final one of a frame |
| evt_buf_done | output | 1 | One-cycle pulse per buffer released |
| evt_frame_done | output | 1 | One-cycle pulse per frame completed |
| evt_babble | output | 1 | One-cycle pulse when a buffer was cut by the frame limit |
| busy | output | 1 | A ring pass is in progress |

## Verification
The assertions assume a memory that acknowledges only requested accesses and returns data in the acknowledge cycle. They also assume that the ring start register is not rewritten while a pass is running. The bench's memory model acknowledges in the same cycle as the request. The bench loads the ring start only between passes, after busy has fallen. Stimulus is driven on the falling clock edge, so kicks, enable changes and tx_ready changes never meet a sampling edge. Backpressure comes from a fixed repeating tx_ready pattern that holds a byte for one or two cycles.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int unsigned FLG_OWN  = 15;
    localparam int unsigned FLG_WRAP = 13;
    localparam int unsigned FLG_EOF  = 11;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] count;
    } txr_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_FETCH,
        ST_EMIT,
        ST_WBACK
    } txr_state_e;

    function automatic logic [7:0] lane_of(input logic [31:0] word, input logic [1:0] off);
        case (off)
            2'd0:    lane_of = word[31:24];
            2'd1:    lane_of = word[23:16];
            2'd2:    lane_of = word[15:8];
            default: lane_of = word[7:0];
        endcase
    endfunction

    function automatic logic [31:0] release_hdr(input txr_hdr_t h);
        txr_hdr_t r;
        r = h;
        r.flags[FLG_OWN] = 1'b0;
        release_hdr = r;
    endfunction

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_wr,
    input  logic [AW-1:0] base_data,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] cur_ptr
);
    localparam logic [AW-1:0] STEP = AW'(8);

    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (base_wr) begin
            base_q <= {base_data[AW-1:2], 2'b00};
            cur_q  <= {base_data[AW-1:2], 2'b00};
        end else if (adv) begin
            cur_q <= wrap ? base_q : cur_q + STEP;
        end
    end

    assign cur_ptr = cur_q;

    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        cur_q[1:0] == 2'b00);

    a_r2_hold_ptr: assert property (@(posedge clk) disable iff (rst)
        (!adv && !base_wr) |=> $stable(cur_q));

    a_r3_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
        (adv && wrap && !base_wr) |=> (cur_q == $past(base_q)));

    a_r3_step_eight: assert property (@(posedge clk) disable iff (rst)
        (adv && !wrap && !base_wr) |=> (cur_q == $past(cur_q) + STEP));
endmodule

// File: rtl/txr_frame_meter.sv
module txr_frame_meter #(
    parameter int unsigned MAX_FRAME = 2032,
    parameter int unsigned LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] req_len,
    input  logic             byte_inc,
    input  logic             frame_clr,
    output logic [LEN_W-1:0] take_len,
    output logic             over
);
    localparam int unsigned CNT_W = $clog2(MAX_FRAME + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_FRAME);

    logic [CNT_W-1:0] fcnt_q;
    logic [CNT_W-1:0] room;

    always_ff @(posedge clk) begin
        if (rst || frame_clr) begin
            fcnt_q <= '0;
        end else if (byte_inc && fcnt_q != LIMIT) begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

    always_comb begin
        room = LIMIT - fcnt_q;
        over = (req_len > LEN_W'(room));
        take_len = over ? LEN_W'(room) : req_len;
    end

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        fcnt_q <= LIMIT);

    a_r10_count_cleared: assert property (@(posedge clk) disable iff (rst)
        frame_clr |=> (fcnt_q == '0));
endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             kick,
    input  logic [AW-1:0]    cur_ptr,
    output logic             ptr_adv,
    output logic             ptr_wrap,
    output logic [LEN_W-1:0] req_len,
    input  logic [LEN_W-1:0] take_len,
    input  logic             over,
    output logic             byte_inc,
    output logic             frame_clr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             evt_buf_done,
    output logic             evt_frame_done,
    output logic             evt_babble,
    output logic             busy
);
    txr_state_e       state_q, state_d;
    txr_hdr_t         hdr_q;
    logic [AW-1:0]    baddr_q;
    logic [LEN_W-1:0] remain_q;
    logic [31:0]      word_q;
    logic             cut_q;
    logic             pend_q, pend_d;
    logic             ev_buf_q, ev_frame_q, ev_bab_q;

    logic kick_ok;
    logic hdr_ack, ptr_ack, fetch_ack, wb_ack, emit_take;
    logic stop_now, restart;
    logic is_eof;

    assign kick_ok   = kick && cfg_en;
    assign hdr_ack   = (state_q == ST_HDR)   && mem_ack;
    assign ptr_ack   = (state_q == ST_PTR)   && mem_ack;
    assign fetch_ack = (state_q == ST_FETCH) && mem_ack;
    assign wb_ack    = (state_q == ST_WBACK) && mem_ack;
    assign emit_take = (state_q == ST_EMIT)  && tx_ready;
    assign is_eof    = hdr_q.flags[FLG_EOF];
    assign stop_now  = hdr_ack && !mem_rdata[16 + FLG_OWN];
    assign restart   = stop_now && (pend_q || kick_ok);

    always_comb begin
        pend_d = pend_q;
        if (kick_ok && state_q != ST_IDLE) pend_d = 1'b1;
        if (restart) pend_d = 1'b0;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (kick_ok) state_d = ST_HDR;
            ST_HDR:   if (mem_ack) begin
                          if (mem_rdata[16 + FLG_OWN]) state_d = ST_PTR;
                          else if (restart)            state_d = ST_HDR;
                          else                         state_d = ST_IDLE;
                      end
            ST_PTR:   if (mem_ack) state_d = (take_len == '0) ? ST_WBACK : ST_FETCH;
            ST_FETCH: if (mem_ack) state_d = ST_EMIT;
            ST_EMIT:  if (tx_ready) begin
                          if (remain_q == LEN_W'(1))      state_d = ST_WBACK;
                          else if (baddr_q[1:0] == 2'd3)  state_d = ST_FETCH;
                      end
            ST_WBACK: if (mem_ack) state_d = ST_HDR;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            hdr_q      <= '0;
            baddr_q    <= '0;
            remain_q   <= '0;
            word_q     <= '0;
            cut_q      <= 1'b0;
            pend_q     <= 1'b0;
            ev_buf_q   <= 1'b0;
            ev_frame_q <= 1'b0;
            ev_bab_q   <= 1'b0;
        end else begin
            state_q    <= state_d;
            pend_q     <= pend_d;
            ev_buf_q   <= wb_ack;
            ev_frame_q <= wb_ack && is_eof;
            ev_bab_q   <= wb_ack && cut_q;
            if (hdr_ack) hdr_q <= txr_hdr_t'(mem_rdata);
            if (ptr_ack) begin
                baddr_q  <= mem_rdata[AW-1:0];
                remain_q <= take_len;
                cut_q    <= over;
            end
            if (fetch_ack) word_q <= mem_rdata;
            if (emit_take) begin
                baddr_q  <= baddr_q + 1'b1;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = release_hdr(hdr_q);
        case (state_q)
            ST_HDR:   mem_req = 1'b1;
            ST_PTR:   begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(4); end
            ST_FETCH: begin mem_req = 1'b1; mem_addr = {baddr_q[AW-1:2], 2'b00}; end
            ST_WBACK: begin mem_req = 1'b1; mem_we = 1'b1; end
            default:  ;
        endcase
    end

    assign req_len        = hdr_q.count;
    assign byte_inc       = emit_take;
    assign frame_clr      = wb_ack && is_eof;
    assign ptr_adv        = wb_ack;
    assign ptr_wrap       = hdr_q.flags[FLG_WRAP];
    assign tx_valid       = (state_q == ST_EMIT);
    assign tx_data        = lane_of(word_q, baddr_q[1:0]);
    assign tx_last        = tx_valid && is_eof && (remain_q == LEN_W'(1));
    assign evt_buf_done   = ev_buf_q;
    assign evt_frame_done = ev_frame_q;
    assign evt_babble     = ev_bab_q;
    assign busy           = (state_q != ST_IDLE);

    a_r6_release_own: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[16 + FLG_OWN]);

    a_r12_hold_byte: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r4_frame_implies_buf: assert property (@(posedge clk) disable iff (rst)
        evt_frame_done |-> evt_buf_done);

    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !cfg_en) |=> !mem_req);

    a_r2_stop_no_write: assert property (@(posedge clk) disable iff (rst)
        (stop_now && !restart) |=> !busy);
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine #(
    parameter int unsigned AW        = 32,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned MAX_FRAME = 2032
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          ring_base_wr,
    input  logic [AW-1:0] ring_base_data,
    input  logic          kick,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          evt_buf_done,
    output logic          evt_frame_done,
    output logic          evt_babble,
    output logic          busy
);
    logic [AW-1:0]    cur_ptr;
    logic             ptr_adv, ptr_wrap;
    logic [LEN_W-1:0] req_len, take_len;
    logic             over, byte_inc, frame_clr;

    txr_ring_ptr #(.AW(AW)) ring_i (
        .clk(clk), .rst(rst),
        .base_wr(ring_base_wr), .base_data(ring_base_data),
        .adv(ptr_adv), .wrap(ptr_wrap), .cur_ptr(cur_ptr)
    );

    txr_frame_meter #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) meter_i (
        .clk(clk), .rst(rst),
        .req_len(req_len), .byte_inc(byte_inc), .frame_clr(frame_clr),
        .take_len(take_len), .over(over)
    );

    txr_seq #(.AW(AW), .LEN_W(LEN_W)) seq_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .kick(kick),
        .cur_ptr(cur_ptr), .ptr_adv(ptr_adv), .ptr_wrap(ptr_wrap),
        .req_len(req_len), .take_len(take_len), .over(over),
        .byte_inc(byte_inc), .frame_clr(frame_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .evt_buf_done(evt_buf_done),
        .evt_frame_done(evt_frame_done), .evt_babble(evt_babble),
        .busy(busy)
    );

    a_r11_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && !tx_valid && !evt_buf_done && !evt_frame_done && !evt_babble));
endmodule

// File: tb/txbd_ring_engine_tb.sv
module txbd_ring_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b1;
    logic        ring_base_wr = 1'b0;
    logic [31:0] ring_base_data = '0;
    logic        kick = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        evt_buf_done, evt_frame_done, evt_babble, busy;

    always #5 clk = ~clk;

    txbd_ring_engine dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en),
        .ring_base_wr(ring_base_wr), .ring_base_data(ring_base_data),
        .kick(kick), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .evt_buf_done(evt_buf_done),
        .evt_frame_done(evt_frame_done), .evt_babble(evt_babble), .busy(busy)
    );

    logic [31:0] mem [0:2047];
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[12:2]];

    int errors = 0;
    int checks = 0;

    int rd_n, wr_n, cap_n, last_n, buf_n, frame_n, bab_n, watch_n, bp_err;
    logic [31:0] first_rd, last_rd, watch_addr;
    logic [7:0]  cap [0:4095];
    int          last_idx [0:7];
    logic [7:0]  exp_b [0:4095];
    int          exp_n;
    logic        bp_mode = 1'b0;
    int          bp_cnt = 0;
    logic        held_v = 1'b0;
    logic [7:0]  held_d;

    function automatic logic [7:0] pat(input int a);
        pat = 8'((a * 7) ^ (a >> 8) ^ 8'h5A);
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr[12:2]] = mem_wdata;
            wr_n++;
        end
        if (mem_req && !mem_we) begin
            if (rd_n == 0) first_rd = mem_addr;
            last_rd = mem_addr;
            if (mem_addr == watch_addr) watch_n++;
            rd_n++;
        end
        if (tx_valid && tx_ready) begin
            cap[cap_n] = tx_data;
            if (tx_last && last_n < 8) begin
                last_idx[last_n] = cap_n;
                last_n++;
            end
            cap_n++;
        end
        if (held_v && !(tx_valid && tx_data == held_d)) bp_err++;
        held_v = tx_valid && !tx_ready;
        held_d = tx_data;
        if (evt_buf_done) buf_n++;
        if (evt_frame_done) frame_n++;
        if (evt_babble) bab_n++;
    end

    always @(negedge clk) begin
        bp_cnt++;
        tx_ready <= bp_mode ? ((bp_cnt % 3) == 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        rd_n = 0; wr_n = 0; cap_n = 0; last_n = 0; buf_n = 0;
        frame_n = 0; bab_n = 0; watch_n = 0; bp_err = 0; exp_n = 0;
        first_rd = '1; last_rd = '1;
    endtask

    task automatic add_exp(input int ptr, input int len);
        for (int i = 0; i < len; i++) begin
            exp_b[exp_n] = pat(ptr + i);
            exp_n++;
        end
    endtask

    task automatic fill_buf(input int ptr, input int len);
        for (int i = 0; i < len; i++) begin
            int a = ptr + i;
            mem[a >> 2][8*(3 - (a % 4)) +: 8] = pat(a);
        end
    endtask

    task automatic put_desc(input int d, input logic [15:0] fl, input int len, input int ptr);
        mem[d >> 2]       = {fl, 16'(len)};
        mem[(d >> 2) + 1] = 32'(ptr);
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        ring_base_wr = 1'b1; ring_base_data = b;
        @(negedge clk);
        ring_base_wr = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        @(negedge clk);
        chk(!busy, "watchdog busy", int'(busy), 0);
    endtask

    task automatic cmp_stream(input string tag);
        int bad = 0;
        for (int i = 0; i < exp_n; i++)
            if (i < cap_n && cap[i] != exp_b[i]) bad++;
        chk(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
        chk(bad == 0, {tag, " byte values"}, bad, 0);
    endtask

    task automatic t_reset();
        chk(!mem_req && !tx_valid && !busy && !evt_buf_done && !evt_frame_done && !evt_babble,
            "R11 reset outputs", {mem_req, tx_valid, busy, evt_buf_done, evt_frame_done, evt_babble}, 0);
    endtask

    task automatic t_single();
        clear_logs();
        fill_buf(32'h1001, 5);
        put_desc(32'h100, 16'h8800, 5, 32'h1001);
        mem[32'h108 >> 2] = '0;
        set_base(32'h100);
        pulse_kick();
        wait_idle();
        add_exp(32'h1001, 5);
        cmp_stream("R1 R13 unaligned single buffer");
        chk(last_n == 1 && last_idx[0] == 4, "R4 last marker position", last_idx[0], 4);
        chk(frame_n == 1 && buf_n == 1, "R4 R6 event counts", frame_n * 16 + buf_n, 16'h11);
        chk(mem[32'h100 >> 2] == {16'h0800, 16'd5}, "R6 written-back header", mem[32'h100 >> 2], {16'h0800, 16'd5});
        chk(last_rd == 32'h108, "R3 step to next slot", last_rd, 32'h108);
    endtask

    task automatic t_wrap_stop();
        clear_logs();
        fill_buf(32'h1100, 3);
        fill_buf(32'h1202, 4);
        put_desc(32'h200, 16'h8000, 3, 32'h1100);
        put_desc(32'h208, 16'hA800, 4, 32'h1202);
        set_base(32'h203);
        pulse_kick();
        wait_idle();
        add_exp(32'h1100, 3);
        add_exp(32'h1202, 4);
        chk(first_rd == 32'h200, "R7 start with low bits cleared", first_rd, 32'h200);
        cmp_stream("R4 two-buffer frame");
        chk(last_n == 1 && last_idx[0] == 6, "R4 only final byte marked", last_n, 1);
        chk(buf_n == 2 && frame_n == 1, "R6 buffer events", buf_n, 2);
        chk(last_rd == 32'h200, "R3 wrap to ring start", last_rd, 32'h200);
        clear_logs();
        pulse_kick();
        wait_idle();
        chk(rd_n == 1 && first_rd == 32'h200, "R2 pointer held at stopped slot", first_rd, 32'h200);
        chk(wr_n == 0 && cap_n == 0, "R2 no write or byte on stop", wr_n + cap_n, 0);
    endtask

    task automatic t_enable();
        clear_logs();
        fill_buf(32'h1300, 1);
        put_desc(32'h200, 16'h8800, 1, 32'h1300);
        mem[32'h208 >> 2] = '0;
        set_base(32'h200);
        cfg_en = 1'b0;
        pulse_kick();
        repeat (20) @(negedge clk);
        chk(rd_n == 0 && !busy, "R8 kick ignored while disabled", rd_n, 0);
        cfg_en = 1'b1;
        pulse_kick();
        wait_idle();
        chk(cap_n == 1 && frame_n == 1, "R8 kick honoured once enabled", cap_n, 1);
    endtask

    task automatic t_backpressure();
        clear_logs();
        fill_buf(32'h1303, 9);
        fill_buf(32'h1400, 6);
        put_desc(32'h300, 16'h8000, 9, 32'h1303);
        put_desc(32'h308, 16'h8800, 6, 32'h1400);
        mem[32'h310 >> 2] = '0;
        set_base(32'h300);
        bp_mode = 1'b1;
        pulse_kick();
        wait_idle();
        bp_mode = 1'b0;
        add_exp(32'h1303, 9);
        add_exp(32'h1400, 6);
        cmp_stream("R12 R13 stream under backpressure");
        chk(bp_err == 0, "R12 byte held while stalled", bp_err, 0);
    endtask

    task automatic t_kick_busy();
        clear_logs();
        fill_buf(32'h1500, 40);
        put_desc(32'h380, 16'h8800, 40, 32'h1500);
        mem[32'h388 >> 2] = '0;
        watch_addr = 32'h388;
        set_base(32'h380);
        pulse_kick();
        repeat (6) @(negedge clk);
        chk(busy, "R9 engine busy at second kick", int'(busy), 1);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        wait_idle();
        chk(watch_n == 2, "R9 stopped slot rescanned", watch_n, 2);
        chk(frame_n == 1 && cap_n == 40, "R9 no extra frame", cap_n, 40);
    endtask

    task automatic t_babble();
        clear_logs();
        watch_addr = '1;
        fill_buf(32'h1000, 2000);
        fill_buf(32'h1800, 100);
        fill_buf(32'h1900, 10);
        put_desc(32'h400, 16'h8000, 2000, 32'h1000);
        put_desc(32'h408, 16'h8800, 100, 32'h1800);
        put_desc(32'h410, 16'hA800, 10, 32'h1900);
        set_base(32'h400);
        pulse_kick();
        wait_idle();
        add_exp(32'h1000, 2000);
        add_exp(32'h1800, 32);
        add_exp(32'h1900, 10);
        cmp_stream("R5 R10 capped frame then fresh frame");
        chk(last_n == 2 && last_idx[0] == 2031, "R5 cut frame ends at limit", last_idx[0], 2031);
        chk(last_idx[1] == 2041, "R10 next frame full length", last_idx[1], 2041);
        chk(bab_n == 1, "R5 babble pulse count", bab_n, 1);
        chk(buf_n == 3 && frame_n == 2, "R6 R4 events on long ring", buf_n * 16 + frame_n, 16'h32);
        chk(mem[32'h408 >> 2] == {16'h0800, 16'd100}, "R6 count kept in write-back", mem[32'h408 >> 2], {16'h0800, 16'd100});
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        watch_addr = '1;
        clear_logs();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_single();
        t_wrap_stop();
        t_enable();
        t_backpressure();
        t_kick_busy();
        t_babble();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule